// File: doc/BRIEF.md
# Burst Memory Read Output Stage with Two-Cycle Deselect

This block sits between the control front-end of a synchronous burst memory and its data pins. Every clock it takes one command from the front-end (read, write, deselect or nothing) along with the word read from the array. It then drives a 32-bit data bus and a per-bit drive-enable vector. A static mode input selects the output latency. In flow-through mode the captured word goes straight to the bus. In pipelined mode, which is the reset default, the word passes through one more rising-edge register first.

Deselect commands travel through the same stages as reads. A deselect does not release the bus at once: the last word stays on the bus for one extra full cycle, and the drivers turn off only after the second rising edge that follows the deselect. An asynchronous active-low output enable can switch the drivers off at any time. It can never switch them on unless the synchronous logic is already driving read data. A sleep input releases the bus. After sleep ends, reads are locked out for a programmable number of recovery cycles.

Top module: `burst_rd_outstage`

## Requirements
- R1: After reset the bus is released (`dq_en` all zero) and the stage uses pipelined latency.
- R2: In flow-through mode (`pipe_mode` = 0), a read sampled at rising edge P puts its word on `dq_o` with `dq_en` all ones right after P.
- R3: In pipelined mode (`pipe_mode` = 1), a read sampled at edge P first appears right after edge P+1.
- R4: Reads on consecutive edges give a new word on the bus every clock, in the order they were issued.
- R5: A deselect sampled at edge P while the stage is driving holds the last word for one extra cycle. The bus is released after edge P+1 in flow-through mode and after edge P+2 in pipelined mode.
- R6: A write sampled at edge P releases the whole bus at the point where a read would have appeared: after P in flow-through mode, after P+1 in pipelined mode.
- R7: While `oe_n` is high, every bit of `dq_en` is low, with no clock needed. Taking `oe_n` low enables the drivers only if a read word is being driven.
- R8: All bits of `dq_en` are equal at all times; reads drive every byte lane.
- R9: If `sleep` is high at an edge, the bus is released after that edge. Reads sampled while `sleep` is high are ignored.
- R10: Reads are also ignored at the first edge where `sleep` is sampled low again and at the RECOV_CYC edges after it (default 2). The next read is accepted.
- R11: A new value on `pipe_mode` takes effect only at an edge where both internal stages are idle. While words are being driven, the old latency stays in force.
- R12: When several commands arrive in one cycle, deselect wins over write and write wins over read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pipe_mode | input | 1 | 1 = pipelined latency, 0 = flow-through latency |
| rd_cmd | input | 1 | Read command for this cycle |
| wr_cmd | input | 1 | Write command for this cycle |
| dsel_cmd | input | 1 | Deselect command for this cycle |
| arr_data | input | 32 | Word read from the array, valid with `rd_cmd` |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Sleep request, sampled at the clock edge |
| dq_o | output | 32 | Data toward the pins |
| dq_en | output | 32 | Per-bit drive enable, 1 = drive |

## Verification
The assertions assume that `sleep` and `pipe_mode` meet setup and hold relative to the rising edge, and that a read command arrives together with its array word. They treat `oe_n` as a level that may change at any time, so the gating check is taken at each edge and is combinational. The bench changes every synchronous input only at falling edges. It pulses `oe_n` inside the low phase and samples the bus at falling edges. The data-arrival and release cycles are therefore counted exactly, for read, deselect and write sequences in both modes.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    // control flags kept by the command capture stage
    typedef struct packed {
        logic en;    // a read word is being driven
        logic pend;  // deselect seen, release after one hold cycle
        logic slp;   // sampled sleep level
    } rdo_flags_t;

endpackage

// File: rtl/rdo_cmd_stage.sv
module rdo_cmd_stage
    import rdo_pkg::*;
#(
    parameter int DW        = 32,
    parameter int RECOV_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_cmd,
    input  logic          wr_cmd,
    input  logic          dsel_cmd,
    input  logic          sleep,
    input  logic [DW-1:0] arr_data,
    output logic          en_o,
    output logic [DW-1:0] data_o,
    output logic          slp_o
);

    localparam int RCW = (RECOV_CYC < 1) ? 1 : $clog2(RECOV_CYC + 1);

    typedef struct packed {
        rdo_flags_t     f;
        logic [RCW-1:0] rcnt;
        logic [DW-1:0]  data;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    logic    rd_ok;

    always_comb begin
        st_d       = st_q;
        st_d.f.slp = sleep;
        rd_ok      = 1'b0;
        if (sleep) begin
            st_d.f.en   = 1'b0;
            st_d.f.pend = 1'b0;
            st_d.rcnt   = '0;
        end else begin
            rd_ok = !st_q.f.slp && (st_q.rcnt == '0);
            if (st_q.f.slp)
                st_d.rcnt = RCW'(RECOV_CYC);
            else if (st_q.rcnt != '0)
                st_d.rcnt = st_q.rcnt - 1'b1;

            if (dsel_cmd) begin
                if (st_q.f.pend) begin
                    st_d.f.en   = 1'b0;
                    st_d.f.pend = 1'b0;
                end else begin
                    st_d.f.pend = st_q.f.en;
                end
            end else if (wr_cmd) begin
                st_d.f.en   = 1'b0;
                st_d.f.pend = 1'b0;
            end else if (rd_cmd && rd_ok) begin
                st_d.f.en   = 1'b1;
                st_d.f.pend = 1'b0;
                st_d.data   = arr_data;
            end else if (st_q.f.pend) begin
                st_d.f.en   = 1'b0;
                st_d.f.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.f.en;
    assign data_o = st_q.data;
    assign slp_o  = st_q.f.slp;

    // R5 R12
    dsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel_cmd && !sleep && en_o && !st_q.f.pend) |=> (en_o && $stable(data_o)));

    // R6
    wr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !dsel_cmd && !sleep) |=> !en_o);

    // R10
    recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rcnt != '0) |-> !en_o);

endmodule

// File: rtl/rdo_dly_reg.sv
module rdo_dly_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [DW-1:0] data_i,
    output logic          en_o,
    output logic [DW-1:0] data_o
);

    typedef struct packed {
        logic          en;
        logic [DW-1:0] data;
    } dly_st_t;

    dly_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.en   = en_i;
        st_d.data = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign data_o = st_q.data;

    // R3
    follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (en_o == $past(en_i)));

endmodule

// File: rtl/burst_rd_outstage.sv
module burst_rd_outstage #(
    parameter int DW        = 32,
    parameter int LANE_W    = 8,
    parameter int RECOV_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic          rd_cmd,
    input  logic          wr_cmd,
    input  logic          dsel_cmd,
    input  logic [DW-1:0] arr_data,
    input  logic          oe_n,
    input  logic          sleep,
    output logic [DW-1:0] dq_o,
    output logic [DW-1:0] dq_en
);

    localparam int NLANE = DW / LANE_W;

    typedef struct packed {
        logic mode;   // 1 = pipelined
    } top_st_t;

    top_st_t       st_d, st_q;
    logic          s1_en, s2_en, slp_q, drv;
    logic [DW-1:0] s1_data, s2_data;

    rdo_cmd_stage #(.DW(DW), .RECOV_CYC(RECOV_CYC)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_cmd   (rd_cmd),
        .wr_cmd   (wr_cmd),
        .dsel_cmd (dsel_cmd),
        .sleep    (sleep),
        .arr_data (arr_data),
        .en_o     (s1_en),
        .data_o   (s1_data),
        .slp_o    (slp_q)
    );

    rdo_dly_reg #(.DW(DW)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (s1_en),
        .data_i (s1_data),
        .en_o   (s2_en),
        .data_o (s2_data)
    );

    always_comb begin
        st_d = st_q;
        if (!s1_en && !s2_en)
            st_d.mode = pipe_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: 1'b1};
        else        st_q <= st_d;
    end

    assign dq_o = st_q.mode ? s2_data : s1_data;
    assign drv  = (st_q.mode ? s2_en : s1_en) && !oe_n && !slp_q;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign dq_en[g*LANE_W +: LANE_W] = {LANE_W{drv}};
    end

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (dq_en == '0));

    // R8
    lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_en == '0) || (&dq_en));

    // R9
    sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (dq_en == '0));

    // R11
    mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.mode) |-> $past(!s1_en && !s2_en));

endmodule

// File: tb/sim_burst_rd_outstage.sv
module sim_burst_rd_outstage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pipe_mode = 1'b1;
    logic        rd_cmd = 1'b0, wr_cmd = 1'b0, dsel_cmd = 1'b0;
    logic [31:0] arr_data = '0;
    logic        oe_n = 1'b0;
    logic        sleep = 1'b0;
    logic [31:0] dq_o, dq_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_rd_outstage u0 (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .dsel_cmd(dsel_cmd),
        .arr_data(arr_data), .oe_n(oe_n), .sleep(sleep),
        .dq_o(dq_o), .dq_en(dq_en)
    );

    task automatic cyc(input logic rd, input logic wr, input logic ds, input logic [31:0] d);
        rd_cmd = rd; wr_cmd = wr; dsel_cmd = ds; arr_data = d;
        @(negedge clk);
    endtask

    task automatic nop();
        cyc(1'b0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic chk(input string req, input logic exp_en, input logic [31:0] exp_d);
        n_chk++;
        if (exp_en) begin
            if (dq_en !== 32'hFFFF_FFFF || dq_o !== exp_d) begin
                n_bad++;
                $display("FAIL %s: en=%h data=%h expected en=ffffffff data=%h",
                         req, dq_en, dq_o, exp_d);
            end
        end else if (dq_en !== 32'h0) begin
            n_bad++;
            $display("FAIL %s: en=%h expected en=00000000", req, dq_en);
        end
    endtask

    task automatic t_reset();
        chk("R1 reset released", 1'b0, 32'h0);
    endtask

    task automatic t_pipe();
        cyc(1, 0, 0, 32'hA0A0_0001); chk("R3 not yet", 0, 0);
        cyc(1, 0, 0, 32'hB0B0_0002); chk("R3 first word", 1, 32'hA0A0_0001);
        cyc(0, 0, 1, 32'h0);          chk("R4 next beat", 1, 32'hB0B0_0002);
        nop();                        chk("R5 pipe hold", 1, 32'hB0B0_0002);
        nop();                        chk("R5 pipe release", 0, 0);
        cyc(1, 0, 0, 32'hC0C0_0003); chk("R3 idle", 0, 0);
        cyc(0, 1, 0, 32'h0);          chk("R6 pipe prior read", 1, 32'hC0C0_0003);
        nop();                        chk("R6 pipe write release", 0, 0);
    endtask

    task automatic t_flow();
        pipe_mode = 1'b0;
        nop(); nop();
        cyc(1, 0, 0, 32'h1111_2222); chk("R2 flow first", 1, 32'h1111_2222);
        cyc(1, 0, 0, 32'h3333_4444); chk("R4 flow beat", 1, 32'h3333_4444);
        cyc(0, 0, 1, 32'h0);          chk("R5 flow hold", 1, 32'h3333_4444);
        nop();                        chk("R5 flow release", 0, 0);
        cyc(0, 1, 0, 32'h0);          chk("R6 write idle", 0, 0);
        cyc(1, 0, 0, 32'h5555_6666); chk("R2 flow read", 1, 32'h5555_6666);
        cyc(0, 1, 0, 32'h0);          chk("R6 flow write release", 0, 0);
    endtask

    task automatic t_prio();
        cyc(1, 1, 0, 32'hDEAD_0001); chk("R12 write over read", 0, 0);
        cyc(1, 0, 0, 32'h0000_7777); chk("R12 setup", 1, 32'h0000_7777);
        cyc(1, 0, 1, 32'hDEAD_0002); chk("R12 deselect over read", 1, 32'h0000_7777);
        cyc(0, 1, 1, 32'h0);          chk("R12 deselect over write", 0, 0);
        nop();
    endtask

    task automatic t_oe();
        cyc(1, 0, 0, 32'h0E0E_1234);  chk("R7 base", 1, 32'h0E0E_1234);
        #2 oe_n = 1'b1;
        #1 chk("R7 async off", 0, 0);
        #2 oe_n = 1'b0;
        #1 chk("R7 async on", 1, 32'h0E0E_1234);
        cyc(0, 0, 1, 32'h0);
        nop();                        chk("R7 idle", 0, 0);
        #2 oe_n = 1'b1;
        #2 oe_n = 1'b0;
        #1 chk("R7 low cannot enable idle", 0, 0);
        @(negedge clk);
    endtask

    task automatic t_sleep();
        cyc(1, 0, 0, 32'h5A5A_0001); chk("R9 base", 1, 32'h5A5A_0001);
        sleep = 1'b1;
        nop();                        chk("R9 sleep release", 0, 0);
        cyc(1, 0, 0, 32'h5A5A_0002); chk("R9 read in sleep", 0, 0);
        sleep = 1'b0;
        cyc(1, 0, 0, 32'h5A5A_0003); chk("R10 exit edge", 0, 0);
        cyc(1, 0, 0, 32'h5A5A_0004); chk("R10 recovery 1", 0, 0);
        cyc(1, 0, 0, 32'h5A5A_0005); chk("R10 recovery 2", 0, 0);
        cyc(1, 0, 0, 32'h5A5A_0006); chk("R10 accepted", 1, 32'h5A5A_0006);
        cyc(0, 1, 0, 32'h0);
        nop();
    endtask

    task automatic t_mode();
        cyc(1, 0, 0, 32'h7700_0001); chk("R11 flow base", 1, 32'h7700_0001);
        pipe_mode = 1'b1;
        cyc(1, 0, 0, 32'h7700_0002); chk("R11 busy keeps flow", 1, 32'h7700_0002);
        cyc(0, 0, 1, 32'h0);
        nop(); nop(); nop(); nop();
        cyc(1, 0, 0, 32'h7700_0003); chk("R11 pipe after idle", 0, 0);
        nop();                        chk("R11 pipe data", 1, 32'h7700_0003);
        cyc(0, 1, 0, 32'h0);
        nop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pipe();
        t_flow();
        t_prio();
        t_oe();
        t_sleep();
        t_mode();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule